// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block steers every CPU access that falls in the upper part of the first megabyte. Given a 20-bit address, a write flag and the system-management-mode state, it decides in the same cycle whether the access is claimed by main DRAM (`dram_sel`). It also decides whether DRAM may be written at that address (`wr_ok`). Accesses that DRAM does not claim go out to the expansion bus. Writes to a read-only shadow region are dropped, so neither DRAM nor the bus takes them.

The decision is programmed through a byte-wide configuration write port. Seven attribute bytes live at offsets 0x59 to 0x5F:
- The high 64 KB region uses one 2-bit field.
- Twelve 16 KB segments each use a 2-bit field, packed two segments to a byte.

One gating byte at offset 0x72 decides the 128 KB video range. The rest of the decoding is a pure combinational path from the access inputs to the two flags, so an access is decided in the cycle it is presented. A register write becomes visible from the cycle after the clock edge that captures it.

The block has no sequencing of its own. The region classifier is an enumerated kind, chosen with a unique case: `RGN_LOW` (below 0xA0000), `RGN_VIDEO` (0xA0000 to 0xBFFFF), `RGN_SEG` (0xC0000 to 0xEFFFF) and `RGN_HIGH` (0xF0000 to 0xFFFFF). Each kind has its own policy arm. There are no state transitions beyond the register captures.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset the byte at 0x72 holds 0x02 (bits 6 and 3 clear) and all attribute bytes hold 0, so every access from 0xA0000 to 0xFFFFF, read or write, gives dram_sel=0 and wr_ok=0.
- R2: Any access below 0xA0000 gives dram_sel=1 and wr_ok=1 regardless of configuration and SMM state.
- R3: Accesses from 0xF0000 to 0xFFFFF use the 2-bit attribute in bits 5:4 of the byte at offset 0x59; bits 3:0 of that byte have no effect.
- R4: Accesses from 0xC0000 to 0xEFFFF fall in segment i = (address − 0xC0000) / 0x4000, i = 0..11. Segment i uses the byte at offset 0x5A + i/2: bits 1:0 for even i, bits 5:4 for odd i.
- R5: Attribute value 3 gives dram_sel=1 and wr_ok=1 for both reads and writes.
- R6: Attribute value 1 gives dram_sel=1, wr_ok=0 on a read, and dram_sel=0, wr_ok=0 on a write (the write is dropped).
- R7: Attribute values 0 and 2 give dram_sel=0 and wr_ok=0 for both reads and writes.
- R8: Accesses from 0xA0000 to 0xBFFFF give dram_sel=1 and wr_ok=1 when bit 6 of the byte at 0x72 is set, or when smm_active is high and bit 3 of that byte is set. Otherwise they give dram_sel=0 and wr_ok=0.
- R9: A configuration write to any offset other than 0x59 to 0x5F and 0x72 changes no decoding result.
- R10: A configuration write captured at a clock edge governs the decoding from the next cycle on. A change of acc_addr, acc_write or smm_active changes the outputs within the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| smm_active | input | 1 | System management mode is active |
| acc_addr | input | 20 | Address of the current access |
| acc_write | input | 1 | Current access is a write |
| dram_sel | output | 1 | Access is claimed by DRAM |
| wr_ok | output | 1 | DRAM may be written at this address |

## Verification
The hardest situation to reach is the SMM-gated video path. There, bit 3 of the gating byte is set while bit 6 is clear, and the result must follow smm_active between two samples with no clock edge in between. The bench programs the gating byte to 0x08 and toggles smm_active while holding the address. It then repeats this with 0x40, where SMM must have no effect.

A second corner is the nibble packing at the boundaries of each segment. The bench writes asymmetric attribute pairs and probes the first and last byte of neighbouring segments. Seeded random writes, including writes to neighbouring offsets that must be ignored, are mixed with random accesses and compared against a bench-side model.

// File: rtl/lmad_pkg.sv
package lmad_pkg;

    // Two-bit shadow attribute encoding
    typedef enum logic [1:0] {
        ATTR_BUS0 = 2'd0,
        ATTR_ROM  = 2'd1,
        ATTR_BUS2 = 2'd2,
        ATTR_RAM  = 2'd3
    } attr_e;

    // Region kinds inside the first megabyte
    typedef enum logic [1:0] {
        RGN_LOW   = 2'd0,
        RGN_VIDEO = 2'd1,
        RGN_SEG   = 2'd2,
        RGN_HIGH  = 2'd3
    } region_e;

    // Configuration offsets (decoded by software, so kept fixed)
    localparam logic [7:0] OFS_HIGH     = 8'h59;
    localparam logic [7:0] OFS_SEG_BASE = 8'h5A;
    localparam logic [7:0] OFS_GATE     = 8'h72;
    localparam logic [7:0] GATE_RESET   = 8'h02;

    // Bit positions inside the gating byte
    localparam int GATE_OPEN_BIT = 6;
    localparam int GATE_SMM_BIT  = 3;

    // Bit position of the high-region attribute
    localparam int HIGH_ATTR_LSB = 4;

endpackage

// File: rtl/lmad_cfg_regs.sv
module lmad_cfg_regs
    import lmad_pkg::*;
#(
    parameter int SEG_COUNT = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_we,
    input  logic [7:0]                  cfg_addr,
    input  logic [7:0]                  cfg_wdata,
    output attr_e                       high_attr,
    output logic [SEG_COUNT-1:0][1:0]   seg_attr,
    output logic                        gate_open,
    output logic                        gate_smm
);

    localparam int SEG_BYTES = (SEG_COUNT + 1) / 2;

    logic [7:0]                 high_byte;
    logic [SEG_BYTES-1:0][7:0]  seg_bytes;
    logic [7:0]                 gate_byte;
    logic [SEG_BYTES-1:0]       seg_hit;
    logic                       high_hit;
    logic                       gate_hit;

    always_comb begin
        high_hit = cfg_we && (cfg_addr == OFS_HIGH);
        gate_hit = cfg_we && (cfg_addr == OFS_GATE);
        for (int j = 0; j < SEG_BYTES; j++) begin
            seg_hit[j] = cfg_we && (cfg_addr == OFS_SEG_BASE + 8'(j));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_byte <= '0;
            seg_bytes <= '0;
            gate_byte <= GATE_RESET;
        end else begin
            if (high_hit) begin
                high_byte <= cfg_wdata;
            end
            for (int j = 0; j < SEG_BYTES; j++) begin
                if (seg_hit[j]) begin
                    seg_bytes[j] <= cfg_wdata;
                end
            end
            if (gate_hit) begin
                gate_byte <= cfg_wdata;
            end
        end
    end

    // Two segments share a byte: even index in the low nibble
    for (genvar i = 0; i < SEG_COUNT; i++) begin : g_unpack
        assign seg_attr[i] = seg_bytes[i / 2][(i % 2) * 4 +: 2];
    end

    assign high_attr = attr_e'(high_byte[HIGH_ATTR_LSB +: 2]);
    assign gate_open = gate_byte[GATE_OPEN_BIT];
    assign gate_smm  = gate_byte[GATE_SMM_BIT];

    // R9
    ignore_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !high_hit && !gate_hit && (seg_hit == '0))
        |=> ($stable(high_byte) && $stable(seg_bytes) && $stable(gate_byte)));

    // R10
    gate_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == OFS_GATE) |=> (gate_byte == $past(cfg_wdata)));

    // R10
    high_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == OFS_HIGH) |=> (high_byte == $past(cfg_wdata)));

endmodule

// File: rtl/lmad_region_dec.sv
module lmad_region_dec
    import lmad_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int SEG_COUNT     = 12,
    parameter int SEG_SIZE_LOG2 = 14
) (
    input  logic [ADDR_W-1:0]               acc_addr,
    output region_e                         rgn,
    output logic [$clog2(SEG_COUNT)-1:0]    seg_idx
);

    localparam int SEG_IDX_W = $clog2(SEG_COUNT);

    // The top nibble of the first megabyte picks the region kind
    always_comb begin
        unique case (acc_addr[ADDR_W-1 -: 4])
            4'hA, 4'hB:       rgn = RGN_VIDEO;
            4'hC, 4'hD, 4'hE: rgn = RGN_SEG;
            4'hF:             rgn = RGN_HIGH;
            default:          rgn = RGN_LOW;
        endcase
    end

    // Segment base 0xC0000 has zeros in the index field
    assign seg_idx = acc_addr[SEG_SIZE_LOG2 +: SEG_IDX_W];

endmodule

// File: rtl/lmad_policy.sv
module lmad_policy
    import lmad_pkg::*;
#(
    parameter int SEG_COUNT = 12
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  region_e                         rgn,
    input  logic [$clog2(SEG_COUNT)-1:0]    seg_idx,
    input  logic [SEG_COUNT-1:0][1:0]       seg_attr,
    input  attr_e                           high_attr,
    input  logic                            gate_open,
    input  logic                            gate_smm,
    input  logic                            smm_active,
    input  logic                            acc_write,
    output logic                            dram_sel,
    output logic                            wr_ok
);

    localparam int SEG_IDX_W = $clog2(SEG_COUNT);
    localparam logic [SEG_IDX_W:0] SEG_LIM = (SEG_IDX_W + 1)'(SEG_COUNT);

    attr_e seg_sel;
    logic  mapped;
    logic  writable;

    always_comb begin
        if ({1'b0, seg_idx} < SEG_LIM) begin
            seg_sel = attr_e'(seg_attr[seg_idx]);
        end else begin
            seg_sel = ATTR_BUS0;
        end
    end

    always_comb begin
        unique case (rgn)
            RGN_LOW: begin
                mapped   = 1'b1;
                writable = 1'b1;
            end
            RGN_VIDEO: begin
                mapped   = gate_open || (smm_active && gate_smm);
                writable = mapped;
            end
            RGN_SEG: begin
                mapped   = (seg_sel == ATTR_ROM) || (seg_sel == ATTR_RAM);
                writable = (seg_sel == ATTR_RAM);
            end
            RGN_HIGH: begin
                mapped   = (high_attr == ATTR_ROM) || (high_attr == ATTR_RAM);
                writable = (high_attr == ATTR_RAM);
            end
        endcase
    end

    assign dram_sel = mapped && (!acc_write || writable);
    assign wr_ok    = mapped && writable;

    // R2
    low_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn == RGN_LOW) |-> (dram_sel && wr_ok));

    // R5
    ram_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn == RGN_HIGH && high_attr == ATTR_RAM) |-> (dram_sel && wr_ok));

    // R6
    rom_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn == RGN_SEG && seg_sel == ATTR_ROM && acc_write) |-> (!dram_sel && !wr_ok));

    // R7
    bus_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn == RGN_HIGH && (high_attr == ATTR_BUS0 || high_attr == ATTR_BUS2))
        |-> (!dram_sel && !wr_ok));

    // R8
    video_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rgn == RGN_VIDEO && !gate_open && !(smm_active && gate_smm))
        |-> (!dram_sel && !wr_ok));

endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
    import lmad_pkg::*;
#(
    parameter int ADDR_W        = 20,
    parameter int SEG_COUNT     = 12,
    parameter int SEG_SIZE_LOG2 = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_addr,
    input  logic [7:0]         cfg_wdata,
    input  logic               smm_active,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic               acc_write,
    output logic               dram_sel,
    output logic               wr_ok
);

    localparam int SEG_IDX_W = $clog2(SEG_COUNT);

    attr_e                      high_attr;
    logic [SEG_COUNT-1:0][1:0]  seg_attr;
    logic                       gate_open;
    logic                       gate_smm;
    region_e                    rgn;
    logic [SEG_IDX_W-1:0]       seg_idx;

    lmad_cfg_regs #(
        .SEG_COUNT (SEG_COUNT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .high_attr (high_attr),
        .seg_attr  (seg_attr),
        .gate_open (gate_open),
        .gate_smm  (gate_smm)
    );

    lmad_region_dec #(
        .ADDR_W        (ADDR_W),
        .SEG_COUNT     (SEG_COUNT),
        .SEG_SIZE_LOG2 (SEG_SIZE_LOG2)
    ) u_dec (
        .acc_addr (acc_addr),
        .rgn      (rgn),
        .seg_idx  (seg_idx)
    );

    lmad_policy #(
        .SEG_COUNT (SEG_COUNT)
    ) u_pol (
        .clk        (clk),
        .rst_n      (rst_n),
        .rgn        (rgn),
        .seg_idx    (seg_idx),
        .seg_attr   (seg_attr),
        .high_attr  (high_attr),
        .gate_open  (gate_open),
        .gate_smm   (gate_smm),
        .smm_active (smm_active),
        .acc_write  (acc_write),
        .dram_sel   (dram_sel),
        .wr_ok      (wr_ok)
    );

    // R6
    wr_ok_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ok |-> dram_sel);

endmodule

// File: tb/legacy_mem_decoder_test.sv
`timescale 1ns/1ps
module legacy_mem_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        smm_active = 1'b0;
    logic [19:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        dram_sel;
    logic        wr_ok;

    int checks = 0;
    int errors = 0;

    // Bench-side shadow of the programmed bytes
    logic [7:0] sh_high;
    logic [7:0] sh_seg [6];
    logic [7:0] sh_gate;

    always #2 clk = ~clk;

    legacy_mem_decoder uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .smm_active (smm_active),
        .acc_addr   (acc_addr),
        .acc_write  (acc_write),
        .dram_sel   (dram_sel),
        .wr_ok      (wr_ok)
    );

    function automatic logic [1:0] expect_out(input logic [19:0] a, input logic w, input logic s);
        logic       m;
        logic       wt;
        logic [1:0] at;
        int         idx;
        if (a < 20'hA0000) begin
            m = 1'b1; wt = 1'b1;
        end else if (a < 20'hC0000) begin
            m = sh_gate[6] || (s && sh_gate[3]);
            wt = m;
        end else begin
            if (a >= 20'hF0000) begin
                at = sh_high[5:4];
            end else begin
                idx = int'(a - 20'hC0000) / 16384;
                at = (idx % 2 == 1) ? sh_seg[idx / 2][5:4] : sh_seg[idx / 2][1:0];
            end
            m  = (at == 2'd1) || (at == 2'd3);
            wt = (at == 2'd3);
        end
        return {m && (!w || wt), m && wt};
    endfunction

    function automatic string req_of(input logic [19:0] a);
        if (a < 20'hA0000) return "R2";
        if (a < 20'hC0000) return "R8";
        if (a < 20'hF0000) return "R4";
        return "R3";
    endfunction

    task automatic cfg_write(input logic [7:0] ofs, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = ofs; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (ofs == 8'h59) sh_high = d;
        else if (ofs >= 8'h5A && ofs <= 8'h5F) sh_seg[ofs - 8'h5A] = d;
        else if (ofs == 8'h72) sh_gate = d;
    endtask

    // Drive an access while clk is low and compare 1 ns later
    task automatic probe(input string req, input logic [19:0] a, input logic w,
                         input logic s, input logic [1:0] exp);
        acc_addr = a; acc_write = w; smm_active = s;
        #1;
        checks++;
        if ({dram_sel, wr_ok} !== exp) begin
            errors++;
            $display("FAIL %s addr=%05h wr=%0b smm=%0b got sel/ok=%b expected %b",
                     req, a, w, s, {dram_sel, wr_ok}, exp);
        end
    endtask

    task automatic probe_m(input string req, input logic [19:0] a, input logic w, input logic s);
        probe(req, a, w, s, expect_out(a, w, s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        sh_high = '0; sh_gate = 8'h02;
        for (int k = 0; k < 6; k++) sh_seg[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: whole window to bus after reset
        probe("R1", 20'hA0000, 1'b0, 1'b1, 2'b00);
        probe("R1", 20'hBFFFF, 1'b1, 1'b1, 2'b00);
        probe("R1", 20'hC0000, 1'b0, 1'b0, 2'b00);
        probe("R1", 20'hE7FFF, 1'b1, 1'b0, 2'b00);
        probe("R1", 20'hFFFFF, 1'b0, 1'b0, 2'b00);

        // R2: below the window
        probe("R2", 20'h00000, 1'b1, 1'b0, 2'b11);
        probe("R2", 20'h9FFFF, 1'b0, 1'b1, 2'b11);

        // R3 / R5: high region read-write
        cfg_write(8'h59, 8'h30);
        probe("R5", 20'hF0000, 1'b1, 1'b0, 2'b11);
        probe("R5", 20'hFFFFF, 1'b0, 1'b0, 2'b11);
        // R3 / R6: read-only
        cfg_write(8'h59, 8'h10);
        probe("R6", 20'hF8000, 1'b0, 1'b0, 2'b10);
        probe("R6", 20'hF8000, 1'b1, 1'b0, 2'b00);
        // R3: low nibble has no effect
        cfg_write(8'h59, 8'h0F);
        probe("R3", 20'hF1234, 1'b0, 1'b0, 2'b00);
        // R7: attribute 2 on high region
        cfg_write(8'h59, 8'h20);
        probe("R7", 20'hF0000, 1'b0, 1'b0, 2'b00);
        probe("R7", 20'hF0000, 1'b1, 1'b0, 2'b00);

        // R4: segment packing at boundaries
        cfg_write(8'h5A, 8'h13);
        probe("R4", 20'hC0000, 1'b1, 1'b0, 2'b11);
        probe("R4", 20'hC3FFF, 1'b1, 1'b0, 2'b11);
        probe("R4", 20'hC4000, 1'b1, 1'b0, 2'b00);
        probe("R4", 20'hC7FFF, 1'b0, 1'b0, 2'b10);
        probe("R4", 20'hC8000, 1'b0, 1'b0, 2'b00);
        cfg_write(8'h5F, 8'h31);
        probe("R4", 20'hE8000, 1'b0, 1'b0, 2'b10);
        probe("R4", 20'hEBFFF, 1'b1, 1'b0, 2'b00);
        probe("R4", 20'hEC000, 1'b1, 1'b0, 2'b11);
        probe("R4", 20'hEFFFF, 1'b0, 1'b0, 2'b11);
        // R7: attribute 2 on segments
        cfg_write(8'h5B, 8'h22);
        probe("R7", 20'hC8000, 1'b0, 1'b0, 2'b00);
        probe("R7", 20'hCC000, 1'b1, 1'b0, 2'b00);

        // R8: SMM-gated video, smm toggled with no clock edge between samples
        cfg_write(8'h72, 8'h08);
        probe("R8", 20'hA8000, 1'b1, 1'b0, 2'b00);
        probe("R10", 20'hA8000, 1'b1, 1'b1, 2'b11);
        probe("R10", 20'hA8000, 1'b0, 1'b0, 2'b00);
        cfg_write(8'h72, 8'h40);
        probe("R8", 20'hBFFFF, 1'b1, 1'b0, 2'b11);
        probe("R8", 20'hA0000, 1'b0, 1'b1, 2'b11);
        cfg_write(8'h72, 8'h02);
        probe("R8", 20'hA0000, 1'b0, 1'b1, 2'b00);

        // R9: neighbouring offsets ignored
        cfg_write(8'h59, 8'h30);
        cfg_write(8'h72, 8'h40);
        cfg_write(8'h58, 8'h00);
        cfg_write(8'h60, 8'h00);
        cfg_write(8'h71, 8'h00);
        cfg_write(8'h73, 8'h00);
        cfg_write(8'hD9, 8'h00);
        probe("R9", 20'hF0000, 1'b1, 1'b0, 2'b11);
        probe("R9", 20'hA0000, 1'b1, 1'b0, 2'b11);
        probe("R9", 20'hC0000, 1'b1, 1'b0, 2'b11);

        // R10: new value governs the cycle right after capture
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'h5C; cfg_wdata = 8'h03;
        acc_addr = 20'hD0000; acc_write = 1'b1; smm_active = 1'b0;
        #1;
        checks++;
        if ({dram_sel, wr_ok} !== 2'b00) begin
            errors++;
            $display("FAIL R10 before capture got %b expected 00", {dram_sel, wr_ok});
        end
        @(negedge clk);
        cfg_we = 1'b0;
        sh_seg[2] = 8'h03;
        probe("R10", 20'hD0000, 1'b1, 1'b0, 2'b11);

        // Seeded random mix of writes and accesses
        for (int n = 0; n < 3000; n++) begin
            int unsigned pick;
            logic [19:0] a;
            pick = $urandom_range(0, 9);
            if (pick < 3) begin
                logic [7:0] ofs;
                case ($urandom_range(0, 3))
                    0: ofs = 8'(8'h58 + $urandom_range(0, 8));
                    1: ofs = 8'(8'h71 + $urandom_range(0, 2));
                    2: ofs = 8'(8'h59 + $urandom_range(0, 6));
                    default: ofs = 8'($urandom_range(0, 255));
                endcase
                cfg_write(ofs, 8'($urandom_range(0, 255)));
            end else begin
                if ($urandom_range(0, 7) == 0) a = 20'($urandom_range(0, 20'h9FFFF));
                else a = 20'($urandom_range(20'hA0000, 20'hFFFFF));
                @(negedge clk);
                probe_m(req_of(a), a, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule